// File: doc/BRIEF.md
# Digital Potentiometer Wiper Controller

This block is the digital core of a single-channel digital potentiometer. A host talks to it over an SPI slave link (mode 0: data sampled on the rising clock edge, driven on the falling edge, chip select active low). The link carries 16-bit frames that read or write a small register bank. The bank holds a 7-bit volatile wiper code, a 7-bit stored initial value and an 8-bit control/status register. One address reaches either the stored initial value or the live wiper code. A control bit picks which one.

The stored copy is emulated with a register and a busy timer. A write to it also moves the wiper and holds a busy flag for a fixed number of system clocks. While the busy flag is high, all register writes are refused. At reset the wiper sits at mid-scale. It takes the stored value once the ready input reports that the supply is good. The shutdown output combines a register bit with an external active-low pin. The SPI pins are sampled into the system clock domain, so SCK must be several system clocks per half period.

The block has no data stream with back-pressure. SPI is clocked entirely by the host, and the register accesses complete in fixed time. Every pin is therefore plain control or status.

Top module: `wp_wiper_ctrl`

## Requirements
- R1: A frame is 16 bits, MSB first. SDI is taken on SCK rising edges and SDO changes on SCK falling edges. The first byte is the instruction: bit 7 = 1 means read and 0 means write, bits 1:0 are the address, and bits 6:2 are ignored. The second byte is the data.
- R2: While CS is high, sdo_oe is low and SCK has no effect. sdo_oe is high only during the data byte of a read frame.
- R3: After reset, no frame is accepted until CS has been seen high and then falls. Clocking SCK with CS held low since reset changes nothing.
- R4: Addresses 1 and 3 are reserved. Reading them returns 0x00 and writing them changes nothing.
- R5: Address 2 reads as {VOL at bit 7, SHDN at bit 6, WIP at bit 5, bits 4:0 = 0}. A write to it sets VOL from data bit 7 and SHDN from data bit 6.
- R6: With VOL = 0, address 0 reads the stored initial value. A write to it stores data bits 6:0 into both the initial value and the wiper, and starts a non-volatile write.
- R7: With VOL = 1, address 0 reads and writes only the wiper, and the stored initial value is left unchanged.
- R8: After a write to the initial value, WIP reads 1 for NV_WRITE_CYCLES system clocks. While WIP is 1, writes to addresses 0 and 2 are rejected. Reads still work.
- R9: At reset the wiper is 0x40, VOL = 0, SHDN = 1 and WIP = 0. On the first cycle that nv_ready is high, the wiper loads the stored initial value.
- R10: shutdown is high exactly when the logical AND of SHDN and shdn_pin_n is 0.
- R11: A frame that CS ends before its 16th bit changes no register.
- R12: The 7-bit registers read back with bit 7 = 0, and data bit 7 is dropped when they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| nv_ready | input | 1 | Supply good; triggers the one-time wiper reload |
| shdn_pin_n | input | 1 | External active-low shutdown pin |
| spi_sck | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sdi | input | 1 | SPI serial data in |
| spi_sdo | output | 1 | SPI serial data out (pad pulls low when enabled and 0) |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo; low means high impedance |
| wiper | output | 7 | Current wiper code |
| shutdown | output | 1 | Shutdown request to the resistor array |

## Verification
Every cycle, the assertions check these rules:
- SDO stays undriven while chip select is high.
- A write commit only happens inside a frame that began properly.
- Busy blocks changes to the wiper, the initial value and the control bits.
- Reserved writes change nothing.
- A stored-value write copies the value into the wiper and raises busy.
- A wiper-only write leaves the stored value alone.

Only the bench scenarios can show the following:
- Bit order and the exact read-back timing on SDO.
- The power-up order: mid-scale first, then the reload.
- The refusal of frames while CS has been held low since reset.
- That cut-short frames are dropped.
- That busy ends after its timer runs out.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int CMD_BITS   = 8;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS;
  localparam int ADDR_BITS  = 2;

  typedef enum logic [ADDR_BITS-1:0] {
    RA_SHARED = 2'd0,
    RA_RSVD1  = 2'd1,
    RA_CTRL   = 2'd2,
    RA_RSVD3  = 2'd3
  } reg_addr_e;

  localparam int CTRL_VOL_BIT  = 7;
  localparam int CTRL_SHDN_BIT = 6;
  localparam int CTRL_WIP_BIT  = 5;
endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RESET_VAL;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/wp_spi_frame.sv
module wp_spi_frame
  import wp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n_s,
  input  logic                 sck_s,
  input  logic                 sdi_s,
  input  logic [DATA_BITS-1:0] rd_data,
  output logic [ADDR_BITS-1:0] rd_addr,
  output logic                 wr_en,
  output logic [ADDR_BITS-1:0] wr_addr,
  output logic [DATA_BITS-1:0] wr_data,
  output logic                 sdo,
  output logic                 sdo_oe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS);

  logic                 cs_d_q, sck_d_q;
  logic                 armed_q, in_frame_q;
  logic [CNT_W-1:0]     bit_cnt_q;
  logic [DATA_BITS-1:0] shreg_q, tx_q;
  logic                 is_rd_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic                 rd_phase_q, sdo_q;
  logic                 wr_en_q;
  logic [DATA_BITS-1:0] wr_data_q;

  logic cs_fall, sck_rise, sck_fall;
  logic [DATA_BITS-1:0] next_byte;

  assign cs_fall   = cs_d_q & ~cs_n_s;
  assign sck_rise  = in_frame_q & ~cs_n_s & sck_s & ~sck_d_q;
  assign sck_fall  = in_frame_q & ~cs_n_s & ~sck_s & sck_d_q;
  assign next_byte = {shreg_q[DATA_BITS-2:0], sdi_s};
  assign rd_addr   = next_byte[ADDR_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q     <= 1'b0;
      sck_d_q    <= 1'b0;
      armed_q    <= 1'b0;
      in_frame_q <= 1'b0;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      tx_q       <= '0;
      is_rd_q    <= 1'b0;
      addr_q     <= '0;
      rd_phase_q <= 1'b0;
      sdo_q      <= 1'b1;
      wr_en_q    <= 1'b0;
      wr_data_q  <= '0;
    end else begin
      cs_d_q  <= cs_n_s;
      sck_d_q <= sck_s;
      wr_en_q <= 1'b0;
      if (cs_n_s) armed_q <= 1'b1;

      if (cs_n_s) begin
        in_frame_q <= 1'b0;
        rd_phase_q <= 1'b0;
      end else if (cs_fall && armed_q) begin
        in_frame_q <= 1'b1;
        bit_cnt_q  <= '0;
        rd_phase_q <= 1'b0;
      end

      if (sck_rise) begin
        shreg_q <= next_byte;
        if (bit_cnt_q != FRAME_END) bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == LAST_CMD) begin
          is_rd_q    <= shreg_q[CMD_BITS-2];
          addr_q     <= next_byte[ADDR_BITS-1:0];
          rd_phase_q <= shreg_q[CMD_BITS-2];
          tx_q       <= rd_data;
        end
        if (bit_cnt_q == LAST_BIT && !is_rd_q) begin
          wr_en_q   <= 1'b1;
          wr_data_q <= next_byte;
        end
      end

      if (sck_fall && rd_phase_q && bit_cnt_q >= DATA_FIRST && bit_cnt_q < FRAME_END) begin
        sdo_q <= tx_q[DATA_BITS-1];
        tx_q  <= {tx_q[DATA_BITS-2:0], 1'b0};
      end
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = addr_q;
  assign wr_data = wr_data_q;
  assign sdo     = sdo_q;
  assign sdo_oe  = in_frame_q & rd_phase_q;

  AST_CS_HIGH_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> !sdo_oe); // R2

  AST_COMMIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_frame_q) && $past(armed_q)); // R11
endmodule

// File: rtl/wp_regbank.sv
module wp_regbank
  import wp_pkg::*;
#(
  parameter int WIPER_BITS = 7,
  parameter int NV_WRITE_CYCLES = 2000,
  parameter logic [WIPER_BITS-1:0] IVR_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  nv_ready,
  input  logic                  shdn_pin_n,
  input  logic                  wr_en,
  input  logic [ADDR_BITS-1:0]  wr_addr,
  input  logic [DATA_BITS-1:0]  wr_data,
  input  logic [ADDR_BITS-1:0]  rd_addr,
  output logic [DATA_BITS-1:0]  rd_data,
  output logic [WIPER_BITS-1:0] wiper,
  output logic                  shutdown
);
  localparam int NV_W = $clog2(NV_WRITE_CYCLES + 1);
  localparam logic [WIPER_BITS-1:0] MID_SCALE = WIPER_BITS'(1 << (WIPER_BITS - 1));
  localparam int PAD = DATA_BITS - WIPER_BITS;

  logic [WIPER_BITS-1:0] wr_q, ivr_q;
  logic                  vol_q, shdn_q, loaded_q;
  logic [NV_W-1:0]       nv_cnt_q;
  logic                  wip;

  assign wip = (nv_cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= MID_SCALE;
      ivr_q    <= IVR_INIT;
      vol_q    <= 1'b0;
      shdn_q   <= 1'b1;
      loaded_q <= 1'b0;
      nv_cnt_q <= '0;
    end else begin
      if (wip) nv_cnt_q <= nv_cnt_q - 1'b1;
      if (!loaded_q && nv_ready) begin
        wr_q     <= ivr_q;
        loaded_q <= 1'b1;
      end else if (wr_en && !wip) begin
        unique case (reg_addr_e'(wr_addr))
          RA_SHARED: begin
            wr_q <= wr_data[WIPER_BITS-1:0];
            if (!vol_q) begin
              ivr_q    <= wr_data[WIPER_BITS-1:0];
              nv_cnt_q <= NV_W'(NV_WRITE_CYCLES);
            end
          end
          RA_CTRL: begin
            vol_q  <= wr_data[CTRL_VOL_BIT];
            shdn_q <= wr_data[CTRL_SHDN_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (reg_addr_e'(rd_addr))
      RA_SHARED: rd_data = {{PAD{1'b0}}, (vol_q ? wr_q : ivr_q)};
      RA_CTRL: begin
        rd_data[CTRL_VOL_BIT]  = vol_q;
        rd_data[CTRL_SHDN_BIT] = shdn_q;
        rd_data[CTRL_WIP_BIT]  = wip;
      end
      default: rd_data = '0;
    endcase
  end

  assign wiper    = wr_q;
  assign shutdown = ~(shdn_q & shdn_pin_n);

  AST_BUSY_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && wip && wr_en) |=> $stable(wr_q) && $stable(ivr_q) && $stable(vol_q) && $stable(shdn_q)); // R8

  AST_RSVD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && wr_en && wr_addr[0]) |=> $stable(wr_q) && $stable(ivr_q) && $stable(vol_q) && $stable(shdn_q)); // R4

  AST_IVR_COPY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && wr_en && !wip && wr_addr == RA_SHARED && !vol_q) |=> (wr_q == ivr_q) && wip); // R6

  AST_VOL_KEEPS_IVR: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && wr_en && wr_addr == RA_SHARED && vol_q) |=> $stable(ivr_q)); // R7
endmodule

// File: rtl/wp_wiper_ctrl.sv
module wp_wiper_ctrl
  import wp_pkg::*;
#(
  parameter int WIPER_BITS = 7,
  parameter int NV_WRITE_CYCLES = 2000,
  parameter logic [WIPER_BITS-1:0] IVR_INIT = 7'h2A,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  nv_ready,
  input  logic                  shdn_pin_n,
  input  logic                  spi_sck,
  input  logic                  spi_cs_n,
  input  logic                  spi_sdi,
  output logic                  spi_sdo,
  output logic                  spi_sdo_oe,
  output logic [WIPER_BITS-1:0] wiper,
  output logic                  shutdown
);
  logic [2:0]           pins_s;
  logic [ADDR_BITS-1:0] rd_addr, wr_addr;
  logic [DATA_BITS-1:0] rd_data, wr_data;
  logic                 wr_en;

  wp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b000)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_cs_n, spi_sck, spi_sdi}),
    .dout (pins_s)
  );

  wp_spi_frame u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n_s (pins_s[2]),
    .sck_s  (pins_s[1]),
    .sdi_s  (pins_s[0]),
    .rd_data(rd_data),
    .rd_addr(rd_addr),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .sdo    (spi_sdo),
    .sdo_oe (spi_sdo_oe)
  );

  wp_regbank #(
    .WIPER_BITS     (WIPER_BITS),
    .NV_WRITE_CYCLES(NV_WRITE_CYCLES),
    .IVR_INIT       (IVR_INIT)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .nv_ready  (nv_ready),
    .shdn_pin_n(shdn_pin_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wiper     (wiper),
    .shutdown  (shutdown)
  );
endmodule

// File: tb/wp_wiper_ctrl_tb.sv
module wp_wiper_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int NVC = 1500;
  localparam logic [6:0] IVR0 = 7'h2A;
  localparam int WATCHDOG = 190000;

  logic clk = 0, rst_n = 0, nv_ready = 0, shdn_pin_n = 1;
  logic spi_sck = 0, spi_cs_n = 0, spi_sdi = 0;
  logic spi_sdo, spi_sdo_oe, shutdown;
  logic [6:0] wiper;

  int n_chk = 0, n_bad = 0;
  logic [6:0] m_wr, m_ivr;
  logic m_vol, m_shdn, m_wip;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_wiper_ctrl #(.NV_WRITE_CYCLES(NVC), .IVR_INIT(IVR0)) u_dut (
    .clk(clk), .rst_n(rst_n), .nv_ready(nv_ready), .shdn_pin_n(shdn_pin_n),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_sdi(spi_sdi),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe), .wiper(wiper), .shutdown(shutdown)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: exp_read = {1'b0, (m_vol ? m_wr : m_ivr)};
      2'd2: exp_read = {m_vol, m_shdn, m_wip, 5'b0};
      default: exp_read = 8'h00;
    endcase
  endfunction

  // returns 1 when an initial-value write was accepted
  function automatic logic model_write(input logic [1:0] a, input logic [7:0] d);
    model_write = 1'b0;
    if (!m_wip) begin
      if (a == 2'd0) begin
        m_wr = d[6:0];
        if (!m_vol) begin m_ivr = d[6:0]; m_wip = 1'b1; model_write = 1'b1; end
      end else if (a == 2'd2) begin
        m_vol = d[7]; m_shdn = d[6];
      end
    end
  endfunction

  task automatic shift_bits(input logic [15:0] frm, input int nbits,
                            output logic [7:0] rd, output logic oe8);
    rd = 8'h00; oe8 = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      spi_sdi = frm[15-i];
      repeat (HALF) @(negedge clk);
      if (i >= 8) rd[15-i] = spi_sdo;
      if (i == 8) oe8 = spi_sdo_oe;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic rd_n_wr, input logic [1:0] a, input logic [7:0] d,
                      input int nbits, output logic [7:0] rd, output logic oe8);
    logic [7:0] ins;
    ins = {rd_n_wr, 5'($urandom), a};   // R1: bits 6:2 are ignored
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    shift_bits({ins, d}, nbits, rd, oe8);
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    check("R2 sdo_oe low with CS high", {7'b0, spi_sdo_oe}, 8'h00);
    repeat (HALF) @(negedge clk);
  endtask

  task automatic do_read(input string req, input logic [1:0] a);
    logic [7:0] rd; logic oe8;
    xfer(1'b1, a, 8'h00, 16, rd, oe8);
    check(req, rd, exp_read(a));
    check("R2 sdo_oe high in read data byte", {7'b0, oe8}, 8'h01);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] rd; logic oe8;
    xfer(1'b0, a, d, 16, rd, oe8);
    void'(model_write(a, d));
    check("R2 sdo_oe stays low in write", {7'b0, oe8}, 8'h00);
  endtask

  task automatic check_outs(input string req);
    check({req, " wiper"}, {1'b0, wiper}, {1'b0, m_wr});
    check("R10 shutdown", {7'b0, shutdown}, {7'b0, ~(m_shdn & shdn_pin_n)});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd; logic oe8;
    void'($urandom(32'd20240611));
    m_wr = 7'h40; m_ivr = IVR0; m_vol = 0; m_shdn = 1; m_wip = 0;
    // Reset with CS held low
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R9 mid-scale before ready", {1'b0, wiper}, 8'h40);
    check("R9 shutdown inactive at reset", {7'b0, shutdown}, 8'h00);
    nv_ready = 1;
    repeat (3) @(negedge clk);
    m_wr = IVR0;
    check("R9 reload from stored value", {1'b0, wiper}, {1'b0, IVR0});
    // R3: CS never went high since reset; a write of SHDN=0 must be ignored
    shift_bits({8'h02, 8'h00}, 16, rd, oe8);
    repeat (HALF) @(negedge clk);
    check("R3 frame without CS fall ignored", {7'b0, shutdown}, 8'h00);
    spi_cs_n = 1;
    repeat (4*HALF) @(negedge clk);
    // R2: SCK toggles with CS high have no effect
    shift_bits({8'h02, 8'h00}, 16, rd, oe8);
    check("R2 SCK ignored with CS high", {7'b0, shutdown}, 8'h00);

    do_read("R5 R9 control reset value", 2'd2);
    do_read("R6 read stored value", 2'd0);
    shdn_pin_n = 0; repeat (2) @(negedge clk);
    check_outs("R10 pin low");
    shdn_pin_n = 1; repeat (2) @(negedge clk);

    // R7: wiper-only access
    do_write(2'd2, 8'h80);
    do_write(2'd0, 8'h7F);
    check_outs("R7 volatile write");
    do_read("R7 R12 read wiper", 2'd0);
    do_write(2'd2, 8'h40);
    do_read("R7 stored value unchanged", 2'd0);

    // R6/R8/R12: stored write, then busy rejection
    do_write(2'd0, 8'h91);
    check_outs("R6 R12 copy to wiper");
    do_read("R8 busy flag set", 2'd2);
    do_write(2'd2, 8'hC0);
    do_write(2'd0, 8'h05);
    check_outs("R8 writes rejected while busy");
    do_read("R8 control unchanged while busy", 2'd2);
    repeat (NVC) @(negedge clk);
    m_wip = 0;
    do_read("R8 busy cleared", 2'd2);

    // R4: reserved addresses
    do_write(2'd1, 8'hFF);
    do_write(2'd3, 8'h00);
    do_read("R4 reserved reads zero", 2'd1);
    do_read("R4 reserved 3 reads zero", 2'd3);
    check_outs("R4 reserved write no effect");

    // R11: frames cut short
    xfer(1'b0, 2'd2, 8'h00, 12, rd, oe8);
    xfer(1'b0, 2'd0, 8'h13, 15, rd, oe8);
    check_outs("R11 short frames dropped");
    do_read("R11 control intact", 2'd2);
    do_read("R11 stored intact", 2'd0);

    // Constrained random mix
    for (int k = 0; k < 120; k++) begin
      logic is_rd; logic [1:0] a; logic [7:0] d; int nb; logic [7:0] exp;
      is_rd = $urandom_range(1, 0) == 1;
      a = 2'($urandom);
      d = 8'($urandom);
      nb = ($urandom_range(5, 0) == 0) ? $urandom_range(15, 1) : 16;
      if ($urandom_range(7, 0) == 0) shdn_pin_n = ~shdn_pin_n;
      exp = exp_read(a);
      xfer(is_rd, a, d, nb, rd, oe8);
      if (is_rd && nb == 16) check("R1 R5 R6 random read", rd, exp);
      if (!is_rd && nb == 16) begin
        if (model_write(a, d)) begin
          repeat (NVC + 50) @(negedge clk);
          m_wip = 0;
        end
      end
      check_outs("R11 R6 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule